// File: doc/BRIEF.md
# Dual-Mode Processor Register Slave

This block lets an external processor reach a small on-chip register file over an 8-bit data bus. A static mode input picks how the bus is used. With the input low, every address is one byte register and each access moves a single byte. With the input high, registers are 32 bits wide, only the upper six address bits select them, and every access is a frame of four byte beats. Each beat follows a strobe/ready handshake that always adds one wait state. The block also decides when the read-data drivers are enabled.

Behind the bus sit four kinds of register. The first is an interrupt event register, whose bits latch and hold until cleared. The second is a mask register that gates the event bits onto one interrupt line. The third is a parity-control register that turns on even-parity checking of the address bus and of the write-data bus. The last is a set of self-holding reset bits. One of these holds the ingress and egress interfaces in reset. Three others are separate clock-generator resets.

Top module: `preg_dual_if`

## Requirements
- R1: With `burstMode` low, `busAddr[7:2]` picks a 32-bit word and `busAddr[1:0]` picks its byte lane (0 is bits [7:0]). One beat reads or writes exactly that byte, and writes to the other lanes leave it unchanged.
- R2: With `burstMode` high, `busAddr[1:0]` is ignored. A frame of four beats, held under one `busCs` assertion, moves word bits [7:0], [15:8], [23:16] and [31:24] in that order.
- R3: A write frame in burst mode changes the register only after its fourth beat. When `busCs` drops after an incomplete frame, nothing is written, and the next frame starts again at bits [7:0].
- R4: A read frame in burst mode takes a copy of the whole word on its first beat. Later beats return bytes of that copy, even if the register changes during the frame.
- R5: A beat starts when `busStb` and `busCs` are both sampled high while the block is idle. `busRdy` is then high for exactly one cycle, on the second clock edge after that sample. `busOe` is high only in that cycle, and only for reads.
- R6: Event register at 0x00, bits [INT_W-1:0]. Bit i is set by a high `intSrc[i]` and stays set until a write with 1 in that bit position. When the source is high in the same cycle as the clear, the bit stays set.
- R7: `intOut` is high exactly when some event bit is set and the bit in the same position of the mask register at 0x04 is also 1.
- R8: Parity-control register at 0x08: bit 0 enables the address check and bit 1 enables the data check. Parity is even: `busAddrPar` is chosen so that `{busAddr,busAddrPar}` has an even count of ones, and `busDataPar` does the same for `busWdata` on writes. When an enabled check fails, `parErr` is high together with `busRdy`, and the write is discarded (in burst mode, the whole frame is discarded). When the checks are disabled, no error is flagged.
- R9: Bit 8 of the word at 0xA0 drives `ifRst`, and in byte mode it is reached as bit 0 at byte 0xA1. While this bit is 1, `ingressEn` and `egressEn` are low. The bit changes only when software writes it.
- R10: Bit 15 of the words at 0x90, 0x94 and 0x9C drives `pllRst[0]`, `pllRst[1]` and `pllRst[2]`, and in byte mode each is reached as bit 7 at byte 0x91, 0x95 and 0x9D. Each bit is set and cleared alone, and it changes only on a write to its own word.
- R11: After reset, every register is 0, so `ifRst`, `pllRst`, `intOut`, `parErr`, `busRdy` and `busOe` are low and `ingressEn` and `egressEn` are high.
- R12: Addresses that are not mapped read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| burstMode | input | 1 | 0: byte registers, 1: 32-bit registers in four-beat frames |
| busCs | input | 1 | Chip select; in burst mode it frames one four-beat access |
| busStb | input | 1 | Beat request, held until `busRdy` |
| busRnw | input | 1 | 1 read, 0 write |
| busAddr | input | 8 | Address |
| busAddrPar | input | 1 | Even-parity bit for the address |
| busWdata | input | 8 | Write data |
| busDataPar | input | 1 | Even-parity bit for the write data |
| busRdata | output | 8 | Read data, valid while `busRdy` is high |
| busRdy | output | 1 | Beat complete, one cycle |
| busOe | output | 1 | Read-data driver enable |
| parErr | output | 1 | Parity mismatch on this beat |
| intSrc | input | INT_W | Interrupt sources |
| intOut | output | 1 | Masked interrupt to the processor |
| ifRst | output | 1 | Ingress/egress interface reset |
| ingressEn | output | 1 | Ingress interface enable |
| egressEn | output | 1 | Egress interface enable |
| pllRst | output | 3 | Separate clock-generator resets |

## Verification
The byte-lane pattern drives single-byte writes to different lanes of the same words and reads them back. This separates lane selection from full-word writes and shows that each clock-generator reset bit moves on its own. Full four-beat frames with nonzero low address bits check the beat order and show that the low address bits are ignored in burst mode. A frame cut off after two beats, followed by a full frame, tells a beat counter that restarts on chip select from one that keeps running. A pulse on an interrupt source placed between two read beats separates snapshot reads from live reads. Holding a source high across a clear shows that a new event wins over the clear. Writes and reads with corrupted parity, sent with checking on and then off, separate a discarded write from a committed one.

// File: rtl/preg_pkg.sv
package preg_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_ACK} phase_t;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic       wrByte;  // single byte write (byte mode)
    logic       stage;   // stash one burst write byte
    logic       commit;  // write the assembled 32-bit word
    logic       rdLive;  // load read byte from live word, refresh snapshot
    logic       rdSnap;  // load read byte from snapshot
    logic [1:0] lane;    // byte lane of this beat
  } strobe_t;

  localparam logic [5:0] IDX_EVT   = 6'h00;
  localparam logic [5:0] IDX_MASK  = 6'h01;
  localparam logic [5:0] IDX_PAR   = 6'h02;
  localparam logic [5:0] IDX_PLL0  = 6'h24;
  localparam logic [5:0] IDX_PLL1  = 6'h25;
  localparam logic [5:0] IDX_PLL2  = 6'h27;
  localparam logic [5:0] IDX_IFRST = 6'h28;
  localparam int PLL_BIT   = 15;
  localparam int IFRST_BIT = 8;
endpackage

// File: rtl/preg_ctrl.sv
module preg_ctrl
  import preg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstMode,
  input  logic       busCs,
  input  logic       busStb,
  input  logic       busRnw,
  input  logic [7:0] busAddr,
  input  logic       busAddrPar,
  input  logic [7:0] busWdata,
  input  logic       busDataPar,
  input  logic       chkAddr,
  input  logic       chkData,
  output strobe_t    stb,
  output logic       busRdy,
  output logic       busOe,
  output logic       parErr
);
  phase_t     phase;
  logic [1:0] beat;
  logic       burstBad;
  logic       rnwQ;
  logic       addrBad, dataBad, beatBad, fire;

  assign addrBad = chkAddr && (^{busAddr, busAddrPar});
  assign dataBad = chkData && !busRnw && (^{busWdata, busDataPar});
  assign beatBad = addrBad || dataBad;
  assign fire    = (phase == PH_WAIT);

  always_comb begin
    stb      = '0;
    stb.lane = burstMode ? beat : busAddr[1:0];
    if (fire) begin
      if (busRnw) begin
        if (burstMode && beat != 2'd0) stb.rdSnap = 1'b1;
        else                           stb.rdLive = 1'b1;
      end else if (burstMode) begin
        stb.stage  = 1'b1;
        stb.commit = (beat == 2'd3) && !burstBad && !beatBad;
      end else begin
        stb.wrByte = !beatBad;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      beat     <= '0;
      burstBad <= 1'b0;
      rnwQ     <= 1'b0;
      parErr   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (busCs && busStb) phase <= PH_WAIT;
        PH_WAIT: phase <= PH_ACK;
        default: phase <= PH_IDLE;
      endcase
      parErr <= fire && beatBad;
      if (fire) rnwQ <= busRnw;
      if (!busCs) begin
        beat     <= '0;
        burstBad <= 1'b0;
      end else if (fire && burstMode) begin
        beat     <= beat + 2'd1;
        burstBad <= (beat == 2'd3) ? 1'b0 : (burstBad || beatBad);
      end
    end
  end

  assign busRdy = (phase == PH_ACK);
  assign busOe  = busRdy && rnwQ;
endmodule

// File: rtl/preg_dpath.sv
module preg_dpath
  import preg_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [5:0]       wIdx,
  input  logic [7:0]       busWdata,
  input  logic [INT_W-1:0] intSrc,
  output logic [7:0]       busRdata,
  output logic             chkAddr,
  output logic             chkData,
  output logic             intOut,
  output logic             ifRst,
  output logic [2:0]       pllRst
);
  localparam int NUM_PLL = 3;
  localparam logic [31:0] INT_KEEP = 32'((64'd1 << INT_W) - 64'd1);
  localparam logic [5:0] PLL_IDX [NUM_PLL] = '{IDX_PLL0, IDX_PLL1, IDX_PLL2};

  logic [31:0] evQ, maskQ, snapQ, live, wrWord, bitEn;
  logic [23:0] stageQ;
  logic [3:0]  byteEn;
  logic [1:0]  parEnQ;
  logic        ifRstQ, wrAny;
  logic [7:0]  rdQ;

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] l);
    return w[8*l +: 8];
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [31:0] en);
    return (old & ~en) | (nw & en);
  endfunction

  assign wrAny  = stb.wrByte || stb.commit;
  assign byteEn = stb.commit ? 4'hF : (4'b0001 << stb.lane);
  assign bitEn  = {{8{byteEn[3]}}, {8{byteEn[2]}}, {8{byteEn[1]}}, {8{byteEn[0]}}};
  assign wrWord = stb.commit ? {busWdata, stageQ} : {4{busWdata}};

  for (genvar g = 0; g < NUM_PLL; g++) begin : gPll
    logic q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= 1'b0;
      else if (wrAny && wIdx == PLL_IDX[g] && bitEn[PLL_BIT]) q <= wrWord[PLL_BIT];
    end
    assign pllRst[g] = q;
  end

  always_comb begin
    live = '0;
    if (wIdx == IDX_EVT)   live = evQ;
    if (wIdx == IDX_MASK)  live = maskQ;
    if (wIdx == IDX_PAR)   live[1:0] = parEnQ;
    if (wIdx == IDX_IFRST) live[IFRST_BIT] = ifRstQ;
    for (int i = 0; i < NUM_PLL; i++)
      if (wIdx == PLL_IDX[i]) live[PLL_BIT] = pllRst[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evQ    <= '0;
      maskQ  <= '0;
      parEnQ <= '0;
      ifRstQ <= 1'b0;
      stageQ <= '0;
      snapQ  <= '0;
      rdQ    <= '0;
    end else begin
      // new events win over a same-cycle clear
      evQ <= ((evQ & ~((wrAny && wIdx == IDX_EVT) ? (wrWord & bitEn) : 32'h0))
              | 32'(intSrc)) & INT_KEEP;
      if (wrAny && wIdx == IDX_MASK)  maskQ  <= merge(maskQ, wrWord, bitEn) & INT_KEEP;
      if (wrAny && wIdx == IDX_PAR && bitEn[0]) parEnQ <= wrWord[1:0];
      if (wrAny && wIdx == IDX_IFRST && bitEn[IFRST_BIT]) ifRstQ <= wrWord[IFRST_BIT];
      if (stb.stage) begin
        case (stb.lane)
          2'd0:    stageQ[7:0]   <= busWdata;
          2'd1:    stageQ[15:8]  <= busWdata;
          2'd2:    stageQ[23:16] <= busWdata;
          default: ;
        endcase
      end
      if (stb.rdLive) begin
        rdQ   <= pick(live, stb.lane);
        snapQ <= live;
      end else if (stb.rdSnap) begin
        rdQ <= pick(snapQ, stb.lane);
      end
    end
  end

  assign busRdata = rdQ;
  assign chkAddr  = parEnQ[0];
  assign chkData  = parEnQ[1];
  assign intOut   = |(evQ & maskQ);
  assign ifRst    = ifRstQ;
endmodule

// File: rtl/preg_dual_if.sv
module preg_dual_if
  import preg_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstMode,
  input  logic             busCs,
  input  logic             busStb,
  input  logic             busRnw,
  input  logic [7:0]       busAddr,
  input  logic             busAddrPar,
  input  logic [7:0]       busWdata,
  input  logic             busDataPar,
  output logic [7:0]       busRdata,
  output logic             busRdy,
  output logic             busOe,
  output logic             parErr,
  input  logic [INT_W-1:0] intSrc,
  output logic             intOut,
  output logic             ifRst,
  output logic             ingressEn,
  output logic             egressEn,
  output logic [2:0]       pllRst
);
  strobe_t stb;
  logic    chkAddr, chkData;

  preg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .burstMode(burstMode), .busCs(busCs), .busStb(busStb),
    .busRnw(busRnw), .busAddr(busAddr), .busAddrPar(busAddrPar), .busWdata(busWdata),
    .busDataPar(busDataPar), .chkAddr(chkAddr), .chkData(chkData), .stb(stb),
    .busRdy(busRdy), .busOe(busOe), .parErr(parErr)
  );

  preg_dpath #(.INT_W(INT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wIdx(busAddr[7:2]), .busWdata(busWdata),
    .intSrc(intSrc), .busRdata(busRdata), .chkAddr(chkAddr), .chkData(chkData),
    .intOut(intOut), .ifRst(ifRst), .pllRst(pllRst)
  );

  assign ingressEn = !ifRst;
  assign egressEn  = !ifRst;
endmodule

// File: rtl/preg_dual_if_chk.sv
module preg_dual_if_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busCs,
  input logic       busStb,
  input logic       busRnw,
  input logic       busRdy,
  input logic       busOe,
  input logic       parErr,
  input logic       intOut,
  input logic       ifRst,
  input logic       ingressEn,
  input logic       egressEn,
  input logic [2:0] pllRst
);
  AST_RDY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busRdy |=> !busRdy);                                             // R5
  AST_RDY_FOLLOWS_STB: assert property (@(posedge clk) disable iff (!rstN)
    busRdy |-> $past(busStb) && $past(busCs));                       // R5
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> busRdy && busRnw);                                     // R5
  AST_PAR_WITH_RDY: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> busRdy);                                              // R8
  AST_INT_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intOut) |-> busRdy && !busRnw);                            // R6
  AST_IF_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    ifRst |-> !ingressEn && !egressEn);                              // R9
  AST_IFRST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ifRst) |-> busRdy && !busRnw);                          // R9
  AST_PLL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pllRst) |-> busRdy && !busRnw);                         // R10
endmodule

bind preg_dual_if preg_dual_if_chk chk_i (.*);

// File: tb/preg_dual_if_tb_top.sv
module preg_dual_if_tb_top;
  localparam int INT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstMode = 1'b0, busCs = 1'b0, busStb = 1'b0, busRnw = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic busAddrPar = 1'b0, busDataPar = 1'b0;
  logic [INT_W-1:0] intSrc = '0;
  logic [7:0] busRdata;
  logic busRdy, busOe, parErr, intOut, ifRst, ingressEn, egressEn;
  logic [2:0] pllRst;

  int vecs = 0, errs = 0;
  int lastWait = 0;
  logic lastPar = 1'b0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  preg_dual_if #(.INT_W(INT_W)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (expQ.size() != 0) chk("R5 pending reads", 32'(expQ.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // monitor: compares each read beat with the scoreboard
  always @(negedge clk) begin
    if (rstN && busRdy) begin
      chk("R5 busOe on read only", busOe, busRnw);
      if (busRnw) begin
        if (expQ.size() == 0) chk("R5 unexpected read", 1, 0);
        else begin
          automatic logic [7:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          chk(t, busRdata, e);
        end
      end
    end
  end

  task automatic beat(input logic rnw, input logic [7:0] a, input logic [7:0] d,
                      input bit badA, input bit badD, input logic [7:0] expRd, input string tag);
    int n;
    if (rnw) begin expQ.push_back(expRd); tagQ.push_back(tag); end
    @(negedge clk);
    busRnw = rnw; busAddr = a; busWdata = d;
    busAddrPar = (^a) ^ badA; busDataPar = (^d) ^ badD; busStb = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!busRdy && n < 20);
    lastWait = n; lastPar = parErr; busStb = 1'b0;
  endtask

  task automatic csSet(input logic v);
    @(negedge clk); busCs = v;
  endtask

  task automatic wrB(input logic [7:0] a, input logic [7:0] d);
    csSet(1); beat(0, a, d, 0, 0, 0, ""); csSet(0);
  endtask

  task automatic rdB(input logic [7:0] a, input logic [7:0] e, input string tag);
    csSet(1); beat(1, a, 0, 0, 0, e, tag); csSet(0);
  endtask

  task automatic wrW(input logic [7:0] a, input logic [31:0] w);
    csSet(1);
    for (int i = 0; i < 4; i++) beat(0, a, w[8*i +: 8], 0, 0, 0, "");
    csSet(0);
  endtask

  task automatic rdW(input logic [7:0] a, input logic [31:0] e, input string tag);
    csSet(1);
    for (int i = 0; i < 4; i++) beat(1, a, 0, 0, 0, e[8*i +: 8], tag);
    csSet(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk("watchdog expired", 1, 0);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 pllRst", pllRst, 0);
    chk("R11 ifRst", ifRst, 0);
    chk("R11 enables", {ingressEn, egressEn}, 2'b11);
    chk("R11 intOut", intOut, 0);
    chk("R11 busRdy/busOe/parErr", {busRdy, busOe, parErr}, 0);

    // byte mode, lanes and clock-generator resets
    wrB(8'h91, 8'h80);
    chk("R5 one wait state", lastWait, 2);
    chk("R10 pll0 set", pllRst, 3'b001);
    wrB(8'h9D, 8'h80);
    chk("R10 pll2 set alone", pllRst, 3'b101);
    wrB(8'h90, 8'hFF);
    chk("R1 other lane leaves bit", pllRst, 3'b101);
    rdB(8'h91, 8'h80, "R1 readback byte 0x91");
    rdB(8'h90, 8'h00, "R1 lane 0 of 0x90");
    rdB(8'h95, 8'h00, "R10 pll1 untouched");
    wrB(8'h91, 8'h00);
    chk("R10 pll0 cleared alone", pllRst, 3'b100);

    // interface reset
    wrB(8'hA1, 8'h01);
    chk("R9 ifRst set", ifRst, 1);
    chk("R9 enables low", {ingressEn, egressEn}, 2'b00);
    rdB(8'hA1, 8'h01, "R9 readback");
    chk("R9 held after read", ifRst, 1);
    wrB(8'hA1, 8'h00);
    chk("R9 enables restored", {ingressEn, egressEn}, 2'b11);

    // unmapped
    wrB(8'h40, 8'hFF);
    rdB(8'h40, 8'h00, "R12 unmapped reads zero");
    chk("R12 no side effect", {pllRst, ifRst}, 4'b1000);

    // interrupts
    @(negedge clk); intSrc = 16'h0004;
    @(negedge clk); intSrc = '0;
    rdB(8'h00, 8'h04, "R6 event latched");
    chk("R7 masked off", intOut, 0);
    wrB(8'h04, 8'h04);
    chk("R7 mask enables intOut", intOut, 1);
    wrB(8'h00, 8'h04);
    chk("R6 clear drops intOut", intOut, 0);
    rdB(8'h00, 8'h00, "R6 event cleared");
    @(negedge clk); intSrc = 16'h0008;
    wrB(8'h00, 8'h08);
    rdB(8'h00, 8'h08, "R6 source wins over clear");
    @(negedge clk); intSrc = '0;
    wrB(8'h00, 8'h08);
    rdB(8'h00, 8'h00, "R6 cleared after source drop");

    // parity
    wrB(8'h08, 8'h03);
    csSet(1); beat(0, 8'h91, 8'h80, 0, 1, 0, ""); csSet(0);
    chk("R8 data parity error", lastPar, 1);
    chk("R8 bad write discarded", pllRst, 3'b100);
    csSet(1); beat(1, 8'h91, 0, 1, 0, 8'h00, "R8 read with bad addr"); csSet(0);
    chk("R8 address parity error", lastPar, 1);
    wrB(8'h08, 8'h00);
    chk("R8 good parity no error", lastPar, 0);
    csSet(1); beat(0, 8'h91, 8'h80, 0, 1, 0, ""); csSet(0);
    chk("R8 check disabled", lastPar, 0);
    chk("R8 write kept when disabled", pllRst, 3'b101);
    wrB(8'h91, 8'h00);

    // burst mode
    @(negedge clk); burstMode = 1'b1;
    csSet(1);
    beat(0, 8'h97, 8'h00, 0, 0, 0, "");
    beat(0, 8'h97, 8'h80, 0, 0, 0, "");
    beat(0, 8'h97, 8'h00, 0, 0, 0, "");
    chk("R3 no commit before beat 4", pllRst, 3'b100);
    beat(0, 8'h97, 8'h00, 0, 0, 0, "");
    chk("R3 commit after beat 4", pllRst, 3'b110);
    chk("R5 burst beat wait", lastWait, 2);
    csSet(0);
    rdW(8'h94, 32'h0000_8000, "R2 burst byte order");
    wrW(8'h94, 32'h0);
    chk("R2 burst clear", pllRst, 3'b100);

    csSet(1);
    beat(0, 8'hA0, 8'h00, 0, 0, 0, "");
    beat(0, 8'hA0, 8'h01, 0, 0, 0, "");
    csSet(0);
    chk("R3 cut frame writes nothing", ifRst, 0);
    wrW(8'hA0, 32'h0000_0100);
    chk("R3 restart at beat 0", ifRst, 1);
    chk("R9 burst enables low", {ingressEn, egressEn}, 2'b00);
    rdW(8'hA0, 32'h0000_0100, "R2 burst read 0xA0");
    wrW(8'hA0, 32'h0);
    chk("R9 burst clear", ifRst, 0);

    // snapshot
    csSet(1);
    beat(1, 8'h00, 0, 0, 0, 8'h00, "R4 beat0");
    @(negedge clk); intSrc = 16'h0200;
    @(negedge clk); intSrc = '0;
    beat(1, 8'h00, 0, 0, 0, 8'h00, "R4 snapshot byte1");
    beat(1, 8'h00, 0, 0, 0, 8'h00, "R4 snapshot byte2");
    beat(1, 8'h00, 0, 0, 0, 8'h00, "R4 snapshot byte3");
    csSet(0);
    rdW(8'h00, 32'h0000_0200, "R4 fresh frame sees event");
    wrW(8'h00, 32'h0000_0200);
    rdW(8'h00, 32'h0, "R6 burst clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule